// File: doc/BRIEF.md
# Rounding Shift-Right Narrowing Packer

This block takes two source vectors, each holding eight unsigned 16-bit elements, and one shift amount that applies to every element. Each element is shifted right logically by that amount, with round-half-up applied first. The result is then cut down to its low 8 bits. The sixteen bytes that come out are packed into a single 128-bit word. The lanes of the low source go to the lower eight bytes, and the lanes of the high source go to the upper eight bytes.

A datapath uses this block to turn two registers of widened intermediate values back into one register of full-width bytes in a single step. The usual case is pixel values after filtering or averaging. The result is registered. A valid strobe goes through the block alongside the data, with one cycle of latency.

Top module: `rsn_packer`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next state has `out_valid` = 0 and `out_data` = 0.
- R2: `out_valid` equals the value `in_valid` had at the previous rising clock edge, so the latency is exactly one cycle.
- R3: For a shift amount s from 1 to 8, each output byte is the low 8 bits of (x + 2^(s-1)) >> s. Here x is the unsigned 16-bit element, and the sum is formed at 17 bits so the carry is kept.
- R4: A shift amount of 0 passes the low byte of each element through unchanged, with no rounding added.
- R5: Element i of `src_lo` (bits 16i+15 down to 16i) lands in output byte i (bits 8i+7 down to 8i). Element i of `src_hi` lands in output byte 8+i.
- R6: Narrowing never saturates; it truncates. For example 0xFFFF with shift 1 gives 0x00, with shift 8 gives 0x00, and 0x00FF with shift 1 gives 0x80.
- R7: A shift amount above 8 (9 to 15) gives the same result as a shift amount of 8.
- R8: While `in_valid` is low, `out_data` keeps its previous value whatever the sources and shift amount are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sources and shift amount are valid this cycle |
| src_lo | input | 128 | Eight 16-bit elements that fill output bytes 0 to 7 |
| src_hi | input | 128 | Eight 16-bit elements that fill output bytes 8 to 15 |
| shamt | input | 4 | Right-shift amount; 0 passes through, above 8 acts as 8 |
| out_valid | output | 1 | Registered result is valid |
| out_data | output | 128 | Sixteen packed 8-bit results |

## Verification
The checker watches four things on every cycle: the reset values, the one-cycle relation between `in_valid` and `out_valid`, the stability of the output while no operation is issued, and the shift-zero case, where every output byte must equal the low byte of the matching source lane one cycle earlier. The rounding arithmetic cannot be checked that way. This covers the half-up increment, the carry into the seventeenth bit, truncation without saturation, and the clamp of large shift amounts. Only the bench's directed scenarios show these. They compare every byte against values computed from the requirements, for each shift amount and for operands chosen to hit the carry boundary.

// File: rtl/rsn_pkg.sv
package rsn_pkg;

    localparam int IN_W      = 16;
    localparam int OUT_W     = 8;
    localparam int DEF_LANES = 8;
    localparam int MAX_SHIFT = OUT_W;
    localparam int SHIFT_W   = $clog2(2 * MAX_SHIFT);

    typedef logic [IN_W-1:0]    elem_in_t;
    typedef logic [OUT_W-1:0]   elem_out_t;
    typedef logic [IN_W:0]      wide_t;
    typedef logic [SHIFT_W-1:0] shamt_t;

    // Decoded shift control shared by all lanes
    typedef struct packed {
        shamt_t amt;
        wide_t  rnd;
    } shift_ctl_t;

    function automatic shamt_t clamp_shift(input shamt_t raw);
        if (raw > shamt_t'(MAX_SHIFT))
            return shamt_t'(MAX_SHIFT);
        return raw;
    endfunction

endpackage

// File: rtl/rsn_shamt_dec.sv
module rsn_shamt_dec
    import rsn_pkg::*;
(
    input  shamt_t     raw,
    output shift_ctl_t ctl
);

    always_comb begin
        ctl.amt = clamp_shift(raw);
        ctl.rnd = '0;
        if (ctl.amt != '0)
            ctl.rnd = wide_t'(1) << (ctl.amt - shamt_t'(1));
    end

endmodule

// File: rtl/rsn_lane.sv
module rsn_lane
    import rsn_pkg::*;
(
    input  elem_in_t   din,
    input  shift_ctl_t ctl,
    output elem_out_t  dout
);

    wide_t sum;
    wide_t shifted;

    always_comb begin
        sum     = {1'b0, din} + ctl.rnd;
        shifted = sum >> ctl.amt;
        dout    = shifted[OUT_W-1:0];
    end

endmodule

// File: rtl/rsn_pack.sv
module rsn_pack
    import rsn_pkg::*;
#(
    parameter int LANES = DEF_LANES
) (
    input  logic [LANES*IN_W-1:0]    src_lo,
    input  logic [LANES*IN_W-1:0]    src_hi,
    input  shift_ctl_t               ctl,
    output logic [2*LANES*OUT_W-1:0] packed_o
);

    localparam int TOTAL = 2 * LANES;

    for (genvar g = 0; g < TOTAL; g++) begin : g_lane
        elem_in_t  sel;
        elem_out_t res;

        if (g < LANES) begin : g_lo
            assign sel = src_lo[g*IN_W +: IN_W];
        end else begin : g_hi
            assign sel = src_hi[(g-LANES)*IN_W +: IN_W];
        end

        rsn_lane lane_i (
            .din  (sel),
            .ctl  (ctl),
            .dout (res)
        );

        assign packed_o[g*OUT_W +: OUT_W] = res;
    end

endmodule

// File: rtl/rsn_packer.sv
module rsn_packer
    import rsn_pkg::*;
#(
    parameter int LANES = DEF_LANES
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [LANES*IN_W-1:0]    src_lo,
    input  logic [LANES*IN_W-1:0]    src_hi,
    input  logic [SHIFT_W-1:0]       shamt,
    output logic                     out_valid,
    output logic [2*LANES*OUT_W-1:0] out_data
);

    localparam int RES_W = 2 * LANES * OUT_W;

    shift_ctl_t       ctl;
    logic [RES_W-1:0] packed_w;

    rsn_shamt_dec dec_i (
        .raw (shamt),
        .ctl (ctl)
    );

    rsn_pack #(.LANES(LANES)) pack_i (
        .src_lo   (src_lo),
        .src_hi   (src_hi),
        .ctl      (ctl),
        .packed_o (packed_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_data <= packed_w;
        end
    end

endmodule

// File: rtl/rsn_packer_chk.sv
module rsn_packer_chk
    import rsn_pkg::*;
#(
    parameter int LANES = DEF_LANES
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic [LANES*IN_W-1:0]    src_lo,
    input logic [LANES*IN_W-1:0]    src_hi,
    input logic [SHIFT_W-1:0]       shamt,
    input logic                     out_valid,
    input logic [2*LANES*OUT_W-1:0] out_data
);

    logic [2*LANES*OUT_W-1:0] low_bytes;

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            low_bytes[i*OUT_W +: OUT_W]         = src_lo[i*IN_W +: OUT_W];
            low_bytes[(i+LANES)*OUT_W +: OUT_W] = src_hi[i*IN_W +: OUT_W];
        end
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0)); // R1

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R2

    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R2

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data)); // R8

    AST_SHIFT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (in_valid && shamt == '0) |=> out_data == $past(low_bytes)); // R4

endmodule

bind rsn_packer rsn_packer_chk #(.LANES(LANES)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .src_lo    (src_lo),
    .src_hi    (src_hi),
    .shamt     (shamt),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/rsn_packer_tb_top.sv
`timescale 1ns/1ps
module rsn_packer_tb_top;

    localparam int LANES = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [127:0] src_lo = '0;
    logic [127:0] src_hi = '0;
    logic [3:0]   shamt = '0;
    logic         out_valid;
    logic [127:0] out_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rsn_packer #(.LANES(LANES)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .src_lo    (src_lo),
        .src_hi    (src_hi),
        .shamt     (shamt),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // Expected byte from R3/R4/R6/R7
    function automatic logic [7:0] ref_byte(input logic [15:0] x, input int s);
        int e;
        logic [16:0] w;
        e = (s > 8) ? 8 : s;
        w = {1'b0, x};
        if (e > 0) w = w + (17'd1 << (e - 1));
        w = w >> e;
        return w[7:0];
    endfunction

    function automatic logic [127:0] ref_vec(input logic [127:0] lo,
                                             input logic [127:0] hi,
                                             input int s);
        logic [127:0] v;
        for (int i = 0; i < 8; i++) begin
            v[i*8 +: 8]     = ref_byte(lo[i*16 +: 16], s);
            v[(i+8)*8 +: 8] = ref_byte(hi[i*16 +: 16], s);
        end
        return v;
    endfunction

    task automatic check(input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one operation and sample the registered result
    task automatic issue(input logic [127:0] lo, input logic [127:0] hi,
                         input int s);
        @(negedge clk);
        in_valid = 1'b1;
        src_lo = lo;
        src_hi = hi;
        shamt = 4'(s);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 out_valid", 128'(out_valid), 128'd0);
        check("R1 out_data", out_data, 128'd0);
    endtask

    task automatic t_latency();
        @(negedge clk);
        check("R2 idle", 128'(out_valid), 128'd0);
        issue(128'h1, 128'h2, 3);
        check("R2 one cycle", 128'(out_valid), 128'd1);
        @(negedge clk);
        check("R2 drop", 128'(out_valid), 128'd0);
    endtask

    task automatic t_shift3();
        logic [127:0] lo = 128'h0007_0008_0003_0004_00FF_0100_7FFC_1234;
        logic [127:0] hi = 128'hFFF8_0805_0004_0BEE_0001_0002_0010_0808;
        issue(lo, hi, 3);
        check("R3 shift3", out_data, ref_vec(lo, hi, 3));
        // Hand-computed: 0x0004>>3 rounds to 1, 0x0003 rounds to 0
        check("R3 round half up", 128'(out_data[39:32]), 128'h01);
        check("R3 below half", 128'(out_data[47:40]), 128'h00);
    endtask

    task automatic t_all_shifts();
        logic [127:0] lo = 128'h8001_4000_2AAA_5555_00FF_F00F_0180_1357;
        logic [127:0] hi = 128'h7FFF_0001_FFFE_8080_0202_C0DE_ABCD_0F0F;
        for (int s = 1; s <= 8; s++) begin
            issue(lo, hi, s);
            check($sformatf("R3 shift=%0d", s), out_data, ref_vec(lo, hi, s));
        end
    endtask

    task automatic t_shift0();
        logic [127:0] lo = 128'hAB01_CD02_EF03_1204_3405_5606_7807_9A08;
        logic [127:0] hi = 128'h00F1_FFF2_80F3_7FF4_01F5_02F6_03F7_04F8;
        issue(lo, hi, 0);
        check("R4 pass low byte", out_data,
              128'hF1F2F3F4F5F6F7F8_0102030405060708);
    endtask

    task automatic t_placement();
        logic [127:0] lo = '0;
        logic [127:0] hi = '0;
        logic [127:0] exp = '0;
        for (int i = 0; i < 8; i++) begin
            lo[i*16 +: 16] = 16'(i + 1) << 4;
            hi[i*16 +: 16] = 16'(i + 9) << 4;
            exp[i*8 +: 8]     = 8'(i + 1);
            exp[(i+8)*8 +: 8] = 8'(i + 9);
        end
        issue(lo, hi, 4);
        check("R5 lane placement", out_data, exp);
    endtask

    task automatic t_wrap();
        logic [127:0] lo = {{7{16'h0000}}, 16'hFFFF};
        logic [127:0] hi = {{7{16'h0000}}, 16'h00FF};
        issue(lo, hi, 1);
        check("R6 ffff shift1", 128'(out_data[7:0]), 128'h00);
        check("R6 00ff shift1", 128'(out_data[71:64]), 128'h80);
        issue({8{16'hFFFF}}, {8{16'hFF7F}}, 8);
        check("R6 carry shift8", out_data, {{8{8'hFF}}, {8{8'h00}}});
    endtask

    task automatic t_clamp();
        logic [127:0] lo = 128'hFF80_FF7F_1280_127F_0080_007F_FFFF_8000;
        logic [127:0] hi = 128'h0180_017F_7F80_7F7F_00FF_0100_4321_ABCD;
        for (int s = 9; s <= 15; s++) begin
            issue(lo, hi, s);
            check($sformatf("R7 shift=%0d", s), out_data, ref_vec(lo, hi, 8));
        end
    endtask

    task automatic t_hold();
        logic [127:0] held;
        issue(128'h1111_2222_3333_4444_5555_6666_7777_8888,
              128'h9999_AAAA_BBBB_CCCC_DDDD_EEEE_FFFF_0000, 2);
        held = out_data;
        src_lo = {8{16'hDEAD}};
        src_hi = {8{16'hBEEF}};
        shamt = 4'd5;
        @(negedge clk);
        @(negedge clk);
        check("R8 hold data", out_data, held);
        check("R8 hold valid", 128'(out_valid), 128'd0);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_latency();
        t_shift3();
        t_all_shifts();
        t_shift0();
        t_placement();
        t_wrap();
        t_clamp();
        t_hold();
        // Reset again after traffic: R1
        @(negedge clk);
        rst = 1'b1;
        t_reset();
        rst = 1'b0;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule